// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This unit produces the register writeback value for the partial left and right unaligned loads of a 64-bit core, in both a 4-byte (word) and an 8-byte (doubleword) form. A single aligned access covers each instruction. The unit outputs that aligned address. The data returned from memory is shifted by a byte offset taken from the low address bits. It is then merged into the old destination register value through a keep mask. An endianness strap decides which variant inverts the byte offset.

The aligned address is combinational from the effective address and the opcode. The merged value, the destination index and the writeback enable are registered on the clock edge that samples `valid_i`. The write enable is suppressed for destination register 0. Left word results are sign-extended to 64 bits. Right word results are zero-extended to 64 bits.

Top module: `ulm_merge`

## Requirements
- R1: `op_i` bit 1 selects the 8-byte lane (1) or the 4-byte lane (0), and bit 0 selects the right form (1) or the left form (0). `mem_addr_o` equals `addr_i` with its low 3 bits cleared (8-byte lane) or its low 2 bits cleared (4-byte lane), in the same cycle.
- R2: With lane size N bytes, the raw offset b is `addr_i` modulo N. The adjusted offset k is b for a left form with `big_endian_i`=1 and for a right form with `big_endian_i`=0. In the other two cases k is N-1-b.
- R3: For a left form, lane byte i (byte 0 least significant) takes memory byte i-k when i>=k and keeps register byte i when i<k.
- R4: For a right form, lane byte i takes memory byte i+k when i<N-k and keeps register byte i when i>=N-k.
- R5: A left word result is sign-extended from bit 31 into bits 63:32.
- R6: A right word result has bits 63:32 zero. With k=0 the whole register is replaced by the zero-extended memory word.
- R7: An 8-byte access with k=0 writes back exactly the memory doubleword.
- R8: `wb_data_o` and `wb_idx_o` load on the rising edge that samples `valid_i`=1 and hold otherwise. `wb_en_o` is high for exactly the cycle after such an edge.
- R9: A sample with `dest_idx_i`=0 leaves `wb_en_o` low.
- R10: While `rst_ni` is low, `wb_en_o`, `wb_idx_o` and `wb_data_o` are zero.
- R11: Word forms ignore bits 63:32 of `mem_data_i` and of `reg_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | Bit 1: 8-byte lane; bit 0: right form |
| big_endian_i | input | 1 | Endianness strap, 1 = big-endian |
| addr_i | input | ADDR_W | Effective (unaligned) address |
| mem_data_i | input | XLEN | Aligned data returned from memory |
| reg_data_i | input | XLEN | Current destination register value |
| dest_idx_i | input | IDX_W | Destination register index |
| mem_addr_o | output | ADDR_W | Aligned memory address |
| wb_en_o | output | 1 | Writeback enable |
| wb_idx_o | output | IDX_W | Writeback register index |
| wb_data_o | output | XLEN | Merged writeback value |

## Verification
The aligned address is due in the same cycle as the stimulus. The merged value, index and enable are due one clock edge after it. The bench drives every stimulus on a falling edge and checks `mem_addr_o` shortly after, before the next rising edge. It then checks the registered outputs at the following falling edge, which is the first one after the capturing rising edge. Each operation is followed by an idle cycle, so held values and the dropped enable are also visible at that sampling point.

// File: rtl/ulm_pkg.sv
package ulm_pkg;
  typedef enum logic [1:0] {
    OP_WLEFT  = 2'd0,
    OP_WRIGHT = 2'd1,
    OP_DLEFT  = 2'd2,
    OP_DRIGHT = 2'd3
  } ulm_op_e;
endpackage

// File: rtl/ulm_offset.sv
module ulm_offset #(
  parameter int unsigned LANE_W = 32
) (
  input  logic [$clog2(LANE_W/8)-1:0] off_i,
  input  logic                        right_i,
  input  logic                        big_endian_i,
  output logic [$clog2(LANE_W)-1:0]   shamt_o
);
  localparam int unsigned OFF_W = $clog2(LANE_W / 8);

  logic             flip;
  logic [OFF_W-1:0] adj;

  // Left forms invert on little-endian, right forms on big-endian.
  assign flip    = ~(right_i ^ big_endian_i);
  assign adj     = flip ? ~off_i : off_i;
  assign shamt_o = {adj, 3'b000};
endmodule

// File: rtl/ulm_lane.sv
module ulm_lane #(
  parameter int unsigned LANE_W = 32
) (
  input  logic [LANE_W-1:0]           mem_i,
  input  logic [LANE_W-1:0]           reg_i,
  input  logic [$clog2(LANE_W/8)-1:0] off_i,
  input  logic                        right_i,
  input  logic                        big_endian_i,
  output logic [LANE_W-1:0]           merged_o
);
  localparam int unsigned SH_W = $clog2(LANE_W);

  logic [SH_W-1:0]   sh;
  logic [SH_W-1:0]   inv;
  logic [LANE_W-1:0] keep_l;
  logic [LANE_W-1:0] keep_r;

  ulm_offset #(.LANE_W(LANE_W)) u_off (
    .off_i        (off_i),
    .right_i      (right_i),
    .big_endian_i (big_endian_i),
    .shamt_o      (sh)
  );

  // Masks are pre-shifted by one, so no shift ever spans the full lane.
  assign inv    = ~sh;
  assign keep_l = {1'b0, {(LANE_W-1){1'b1}}} >> inv;
  assign keep_r = {{(LANE_W-1){1'b1}}, 1'b0} << inv;

  always_comb begin
    if (right_i) merged_o = (mem_i >> sh) | (reg_i & keep_r);
    else         merged_o = (mem_i << sh) | (reg_i & keep_l);
  end
endmodule

// File: rtl/ulm_merge.sv
module ulm_merge
  import ulm_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              big_endian_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   mem_data_i,
  input  logic [XLEN-1:0]   reg_data_i,
  input  logic [IDX_W-1:0]  dest_idx_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [XLEN-1:0]   wb_data_o
);
  localparam int unsigned WORD_W    = XLEN / 2;
  localparam int unsigned NUM_LANES = 2;

  ulm_op_e           op;
  logic              is_dw;
  logic              is_right;
  logic [WORD_W-1:0] word_res;
  logic [XLEN-1:0]   dword_res;
  logic [XLEN-1:0]   res;

  assign op       = ulm_op_e'(op_i);
  assign is_dw    = op_i[1];
  assign is_right = op_i[0];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = WORD_W << g;
    localparam int unsigned OW = $clog2(LW / 8);
    logic [LW-1:0] merged;

    ulm_lane #(.LANE_W(LW)) u_lane (
      .mem_i        (mem_data_i[LW-1:0]),
      .reg_i        (reg_data_i[LW-1:0]),
      .off_i        (addr_i[OW-1:0]),
      .right_i      (is_right),
      .big_endian_i (big_endian_i),
      .merged_o     (merged)
    );

    if (g == 0) begin : g_word
      assign word_res = WORD_W'(merged);
    end else begin : g_dword
      assign dword_res = XLEN'(merged);
    end
  end

  always_comb begin
    mem_addr_o = addr_i;
    if (is_dw) mem_addr_o[2:0] = 3'b000;
    else       mem_addr_o[1:0] = 2'b00;
  end

  always_comb begin
    unique case (op)
      OP_WLEFT:  res = {{WORD_W{word_res[WORD_W-1]}}, word_res};
      OP_WRIGHT: res = {{WORD_W{1'b0}}, word_res};
      default:   res = dword_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      wb_en_o <= valid_i && (dest_idx_i != '0);
      if (valid_i) begin
        wb_idx_o  <= dest_idx_i;
        wb_data_o <= res;
      end
    end
  end
endmodule

// File: rtl/ulm_merge_chk.sv
module ulm_merge_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic              big_endian_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [XLEN-1:0]   mem_data_i,
  input logic [XLEN-1:0]   reg_data_i,
  input logic [IDX_W-1:0]  dest_idx_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wb_en_o,
  input logic [IDX_W-1:0]  wb_idx_o,
  input logic [XLEN-1:0]   wb_data_o
);
  localparam int unsigned WORD_W = XLEN / 2;

  a_r1_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[1] ? (mem_addr_o[2:0] == 3'b000) : (mem_addr_o[1:0] == 2'b00))
    && (mem_addr_o[ADDR_W-1:3] == addr_i[ADDR_W-1:3]));

  a_r3_left_keep_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2 && big_endian_i && addr_i[2:0] == 3'd7)
    |=> (wb_data_o[XLEN-9:0] == $past(reg_data_i[XLEN-9:0])));

  a_r5_left_word_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0)
    |=> (wb_data_o[XLEN-1:WORD_W] == {WORD_W{wb_data_o[WORD_W-1]}}));

  a_r6_right_word_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1) |=> (wb_data_o[XLEN-1:WORD_W] == '0));

  a_r7_dword_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[1] && addr_i[2:0] == 3'd0 && (op_i[0] != big_endian_i))
    |=> (wb_data_o == $past(mem_data_i)));

  a_r8_en_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dest_idx_i != '0) |=> (wb_en_o && wb_idx_o == $past(dest_idx_i)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wb_en_o && $stable(wb_data_o) && $stable(wb_idx_o)));

  a_r9_no_zero_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dest_idx_i == '0) |=> !wb_en_o);
endmodule

bind ulm_merge ulm_merge_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ulm_merge_test.sv
module ulm_merge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = '0;
  logic        be = 1'b0;
  logic [63:0] addr = '0;
  logic [63:0] mem = '0;
  logic [63:0] regv = '0;
  logic [4:0]  dest = '0;
  logic [63:0] mem_addr;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulm_merge uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .big_endian_i(be), .addr_i(addr), .mem_data_i(mem),
    .reg_data_i(regv), .dest_idx_i(dest), .mem_addr_o(mem_addr),
    .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_merge(input logic [1:0] o, input logic e,
                                            input logic [63:0] a, input logic [63:0] m,
                                            input logic [63:0] r);
    int n = o[1] ? 8 : 4;
    int b = o[1] ? int'(a[2:0]) : int'(a[1:0]);
    int k = (o[0] ^ e) ? b : n - 1 - b;
    logic [63:0] res = '0;
    for (int i = 0; i < n; i++) begin
      if (!o[0]) res[i*8 +: 8] = (i >= k) ? m[(i-k)*8 +: 8] : r[i*8 +: 8];
      else       res[i*8 +: 8] = (i < n - k) ? m[(i+k)*8 +: 8] : r[i*8 +: 8];
    end
    if (!o[1] && !o[0]) res[63:32] = {32{res[31]}};
    return res;
  endfunction

  // Drive at falling edge, address checked same cycle, outputs at next falling edge.
  task automatic apply(input logic [1:0] o, input logic e, input logic [63:0] a,
                       input logic [63:0] m, input logic [63:0] r, input logic [4:0] d);
    @(negedge clk);
    op = o; be = e; addr = a; mem = m; regv = r; dest = d; valid = 1'b1;
    #1;
    check("R1 mem_addr", mem_addr, o[1] ? (a & ~64'h7) : (a & ~64'h3));
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic test_reset();
    #1;
    check("R10 wb_en", {63'd0, wb_en}, 64'd0);
    check("R10 wb_idx", {59'd0, wb_idx}, 64'd0);
    check("R10 wb_data", wb_data, 64'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_sweep(input logic [63:0] m, input logic [63:0] r);
    for (int o = 0; o < 4; o++)
      for (int e = 0; e < 2; e++)
        for (int a = 0; a < 8; a++) begin
          logic [63:0] base = 64'h0000_1234_5678_9A00;
          apply(2'(o), 1'(e), base | 64'(a), m, r, 5'd7);
          // R2 offset adjust; R3 left, R4 right, R5/R6 word extension
          check(o[0] ? "R2/R4 merge" : "R2/R3 merge", wb_data,
                ref_merge(2'(o), 1'(e), base | 64'(a), m, r));
          check("R8 wb_en", {63'd0, wb_en}, 64'd1);
          check("R8 wb_idx", {59'd0, wb_idx}, 64'd7);
        end
  endtask

  task automatic test_zero_shift();
    apply(2'd1, 1'b0, 64'h100, 64'hAAAA_BBBB_8765_4321, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3);
    check("R6 full replace word", wb_data, 64'h0000_0000_8765_4321);
    apply(2'd3, 1'b0, 64'h200, 64'h1122_3344_5566_7788, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3);
    check("R7 full replace dword", wb_data, 64'h1122_3344_5566_7788);
    apply(2'd2, 1'b1, 64'h208, 64'h8877_6655_4433_2211, 64'h0, 5'd3);
    check("R7 full replace dword left", wb_data, 64'h8877_6655_4433_2211);
    apply(2'd0, 1'b1, 64'h300, 64'h0000_0000_F000_0001, 64'h0, 5'd3);
    check("R5 sign extend", wb_data, 64'hFFFF_FFFF_F000_0001);
  endtask

  task automatic test_dest_zero();
    apply(2'd3, 1'b1, 64'h13, 64'h1, 64'h2, 5'd0);
    check("R9 wb_en low", {63'd0, wb_en}, 64'd0);
  endtask

  task automatic test_ignore_upper();
    logic [63:0] first;
    apply(2'd1, 1'b1, 64'h41, 64'h0000_0000_CAFE_F00D, 64'h0000_0000_1357_9BDF, 5'd4);
    first = wb_data;
    apply(2'd1, 1'b1, 64'h41, 64'hDEAD_BEEF_CAFE_F00D, 64'h0F0F_0F0F_1357_9BDF, 5'd4);
    check("R11 right upper ignored", wb_data, first);
    apply(2'd0, 1'b0, 64'h42, 64'h0000_0000_0123_4567, 64'h0000_0000_89AB_CDEF, 5'd4);
    first = wb_data;
    apply(2'd0, 1'b0, 64'h42, 64'hFFFF_FFFF_0123_4567, 64'h5555_5555_89AB_CDEF, 5'd4);
    check("R11 left upper ignored", wb_data, first);
  endtask

  task automatic test_hold();
    logic [63:0] prev;
    apply(2'd2, 1'b0, 64'h55, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, 5'd9);
    prev = wb_data;
    @(negedge clk);
    mem = 64'hFFFF; regv = 64'hEEEE; dest = 5'd1;
    @(negedge clk);
    check("R8 data hold", wb_data, prev);
    check("R8 idx hold", {59'd0, wb_idx}, 64'd9);
    check("R8 en drop", {63'd0, wb_en}, 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_sweep(64'h8899_AABB_CCDD_EEFF, 64'h0123_4567_89AB_CDEF);
    test_sweep(64'h7766_5544_3322_1100, 64'hFEDC_BA98_7654_3210);
    test_zero_shift();
    test_dest_zero();
    test_ignore_upper();
    test_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule